// File: doc/BRIEF.md
# Flash Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus and runs a whole erase on its own. A requester pulses `start` with the erase kind and, for a sector erase, the sector address. The controller then issues the six-write command sequence: two unlock writes, the erase setup byte, two more unlock writes, and the erase command. After that it polls the device by reading status bytes until the erase has finished.

The device signals that it is still busy by flipping bit 6 on every read. The controller stops polling when bit 6 reads the same on two reads in a row and bit 7 reads as 1. It then pulses `done`. If it does not see completion within a set number of reads, it pulses `timeout`. The host gives the device no timing during the erase; it only makes status reads. A new request is refused while an erase is in progress.

Top module: `erase_seq_ctrl`

## Requirements
- R1: While reset is asserted and whenever idle, `busy`, `done` and `timeout` are 0, `fl_we_n` and `fl_oe_n` are 1, and `fl_addr` and `fl_wdata` are 0.
- R2: After an accepted start, the first five writes are, in order, AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, and 55h to 2AAh.
- R3: The sixth write is 10h to 555h for a chip erase (`erase_sector`=0) and 30h to the latched sector address for a sector erase (`erase_sector`=1).
- R4: Each write takes one cycle with address and data set up and `fl_we_n` high, then WE_CYC cycles with `fl_we_n` low, then one hold cycle with `fl_we_n` high. Address and data stay constant across all three phases.
- R5: After the sixth write, each status read drives `fl_oe_n` low for RD_CYC cycles and samples `fl_rdata` at the last of those cycles. A single cycle with `fl_oe_n` high separates consecutive reads. During polling, `fl_addr` holds the sector address (0 for a chip erase), `fl_wdata` is 0 and `fl_we_n` stays high.
- R6: Completion is recognised on a read whose bit 6 equals bit 6 of the previous read and whose bit 7 is 1. The first read of an erase can never complete it. The cycle after that read, `done` pulses.
- R7: A status that holds bit 6 steady but keeps bit 7 at 0 never completes the erase.
- R8: If MAX_POLLS reads finish without completion, the cycle after the last read pulses `timeout` instead of `done`.
- R9: `busy` rises in the cycle after an accepted start and stays high through the one-cycle `done` or `timeout` pulse. It falls in the following cycle.
- R10: `start` is ignored whenever `busy` is 1, including the pulse cycle. Such a start changes no output.
- R11: `erase_sector` and `sector_addr` are sampled only when a start is accepted. Later changes on them do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Erase request strobe |
| erase_sector | input | 1 | 1 = sector erase, 0 = chip erase |
| sector_addr | input | ADDR_W | Sector address for a sector erase |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle polling-limit pulse |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rdata | input | 8 | Flash read data |

## Verification
A behavioural flash model toggles bit 6 for a chosen number of reads and then settles with bit 7 set. This lets the bench place completion at the earliest legal read, on the first read, and past the polling limit. A design that trusted the first read, or compared against a stale byte, would raise `done` a read early. A status that freezes bit 6 with bit 7 low must run into `timeout`; a design that ignored bit 7 would finish there. Start pulses arrive mid-erase and on the exact `done` cycle, and the erase inputs are changed right after acceptance. A design that re-armed from the pulse state or kept tracking `sector_addr` would show a stray write or a wrong final address.

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl #(
  parameter int ADDR_W    = 23,
  parameter int WE_CYC    = 3,
  parameter int RD_CYC    = 2,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              erase_sector,
  input  logic [ADDR_W-1:0] sector_addr,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  input  logic [7:0]        fl_rdata
);

  localparam int CMAX  = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int PW    = $clog2(MAX_POLLS + 1);
  localparam logic [ADDR_W-1:0] A_555 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_2AA = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WLOW, S_WHOLD, S_RLOW, S_RGAP, S_DONE, S_TOUT
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [2:0]        step;
  logic [PW-1:0]     polls;
  logic              first, prev6, is_sec;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] wa;
  logic [7:0]        wd;

  always_comb begin
    case (step)
      3'd0:    begin wa = A_555; wd = 8'hAA; end
      3'd1:    begin wa = A_2AA; wd = 8'h55; end
      3'd2:    begin wa = A_555; wd = 8'h80; end
      3'd3:    begin wa = A_555; wd = 8'hAA; end
      3'd4:    begin wa = A_2AA; wd = 8'h55; end
      default: begin wa = is_sec ? tgt : A_555; wd = is_sec ? 8'h30 : 8'h10; end
    endcase
  end

  wire wr_ph   = (st == S_WSET) || (st == S_WLOW) || (st == S_WHOLD);
  wire poll_ph = (st == S_RLOW) || (st == S_RGAP);
  wire rd_last = (st == S_RLOW) && (cnt == CW'(RD_CYC - 1));
  wire settled = !first && (fl_rdata[6] == prev6) && fl_rdata[7];

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign timeout  = (st == S_TOUT);
  assign fl_we_n  = (st != S_WLOW);
  assign fl_oe_n  = (st != S_RLOW);
  assign fl_addr  = wr_ph ? wa : (poll_ph ? tgt : '0);
  assign fl_wdata = wr_ph ? wd : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; polls <= '0;
      first <= 1'b1; prev6 <= 1'b0; is_sec <= 1'b0; tgt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          is_sec <= erase_sector;
          tgt    <= erase_sector ? sector_addr : '0;
          step   <= '0;
          st     <= S_WSET;
        end
        S_WSET: begin cnt <= '0; st <= S_WLOW; end
        S_WLOW: begin
          if (cnt == CW'(WE_CYC - 1)) st <= S_WHOLD;
          else cnt <= cnt + 1'b1;
        end
        S_WHOLD: begin
          if (step == 3'd5) begin
            cnt <= '0; polls <= '0; first <= 1'b1; st <= S_RLOW;
          end else begin
            step <= step + 1'b1; st <= S_WSET;
          end
        end
        S_RLOW: begin
          if (rd_last) begin
            cnt   <= '0;
            prev6 <= fl_rdata[6];
            first <= 1'b0;
            polls <= polls + 1'b1;
            if (settled)                          st <= S_DONE;
            else if (polls == PW'(MAX_POLLS - 1)) st <= S_TOUT;
            else                                  st <= S_RGAP;
          end else cnt <= cnt + 1'b1;
        end
        S_RGAP:  st <= S_RLOW;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R5
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || $rose(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R4
  AST_DONE_NEEDS_B7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fl_rdata[7])); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !busy); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R8

endmodule

// File: tb/sim_erase_seq_ctrl.sv
module sim_erase_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 23;
  localparam int WE   = 2;
  localparam int RD   = 2;
  localparam int MAXP = 12;
  localparam int WDOG = 20000;

  typedef struct {
    logic busy, done, tout, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [7:0] data;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, erase_sector = 0;
  logic [AW-1:0] sector_addr = '0;
  logic busy, done, timeout, fl_we_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  erase_seq_ctrl #(.ADDR_W(AW), .WE_CYC(WE), .RD_CYC(RD), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_sector(erase_sector),
    .sector_addr(sector_addr), .busy(busy), .done(done), .timeout(timeout),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_rdata(fl_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0, last_busy = 0;
  exp_t q[$];

  // flash status model
  int total_reads = 0, base = 0, fN = 0;
  bit fstuck = 0;
  logic last_oe = 1;
  always @(negedge clk) begin
    if (fl_oe_n && !last_oe) total_reads <= total_reads + 1;
    last_oe <= fl_oe_n;
  end
  function automatic logic [7:0] fval(int k);
    if (fstuck) return 8'h2A;
    if (k <= fN) return {1'b0, k[0], 6'h15};
    return {1'b1, fN[0], 6'h15};
  endfunction
  assign fl_rdata = fval(total_reads - base + 1);

  function automatic exp_t mk(logic b, logic d, logic t, logic w, logic o,
                              logic [AW-1:0] a, logic [7:0] v, string g);
    exp_t e;
    e.busy = b; e.done = d; e.tout = t; e.we_n = w; e.oe_n = o;
    e.addr = a; e.data = v; e.tag = g;
    return e;
  endfunction

  task automatic push_write(logic [AW-1:0] a, logic [7:0] v, string g);
    q.push_back(mk(1, 0, 0, 1, 1, a, v, g));
    for (int i = 0; i < WE; i++) q.push_back(mk(1, 0, 0, 0, 1, a, v, "R4"));
    q.push_back(mk(1, 0, 0, 1, 1, a, v, "R4"));
  endtask

  task automatic build(bit sec, logic [AW-1:0] sa, int n, bit stuck);
    logic [AW-1:0] tg;
    int d, r;
    tg = sec ? sa : '0;
    push_write(AW'(12'h555), 8'hAA, "R2");
    push_write(AW'(12'h2AA), 8'h55, "R2");
    push_write(AW'(12'h555), 8'h80, "R2");
    push_write(AW'(12'h555), 8'hAA, "R2");
    push_write(AW'(12'h2AA), 8'h55, "R2");
    push_write(sec ? sa : AW'(12'h555), sec ? 8'h30 : 8'h10, "R3");
    d = stuck ? MAXP + 1 : (n == 0 ? 2 : n + 1);
    r = (d > MAXP) ? MAXP : d;
    for (int k = 1; k <= r; k++) begin
      for (int i = 0; i < RD; i++) q.push_back(mk(1, 0, 0, 1, 0, tg, 8'h00, "R5"));
      if (k < r) q.push_back(mk(1, 0, 0, 1, 1, tg, 8'h00, "R5"));
    end
    if (d > MAXP) q.push_back(mk(1, 0, 1, 1, 1, '0, 8'h00, "R8"));
    else          q.push_back(mk(1, 1, 0, 1, 1, '0, 8'h00, "R6"));
  endtask

  task automatic do_start(bit sec, logic [AW-1:0] sa, int n, bit stuck);
    do @(negedge clk); while (q.size() != 0 || last_busy);
    fN = n; fstuck = stuck; base = total_reads;
    start = 1; erase_sector = sec; sector_addr = sa;
    build(sec, sa, n, stuck);
    @(negedge clk);
    start = 0; erase_sector = ~sec; sector_addr = ~sa; // R11: late changes ignored
  endtask

  task automatic chk(string g, string f, logic [31:0] act, logic [31:0] ex);
    if (act !== ex) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h cycle=%0d", g, f, act, ex, cyc);
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (!finished) begin
      if (q.size() != 0) e = q.pop_front();
      else e = mk(0, 0, 0, 1, 1, '0, 8'h00, "R1");
      if (rst_n) last_busy = e.busy;
      vectors++;
      chk(e.busy ? e.tag : "R9", "busy", 32'(busy), 32'(e.busy));
      chk(e.tag, "done", 32'(done), 32'(e.done));
      chk(e.tag, "timeout", 32'(timeout), 32'(e.tout));
      chk(e.tag, "we_n", 32'(fl_we_n), 32'(e.we_n));
      chk(e.tag, "oe_n", 32'(fl_oe_n), 32'(e.oe_n));
      chk(e.tag, "addr", 32'(fl_addr), 32'(e.addr));
      chk(e.tag, "wdata", 32'(fl_wdata), 32'(e.data));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    start = 1;               // R1: start during reset has no effect
    @(negedge clk);
    start = 0; rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 R3 R5 R6: chip erase, completion after 4 reads
    do_start(0, AW'(0), 3, 0);
    // R3 R6: sector erase, device settled on the first read
    do_start(1, AW'(23'h5A5A5), 0, 0);
    // R10 R11: sector erase with starts while busy
    do_start(1, AW'(23'h12345), 5, 0);
    repeat (7) @(negedge clk);
    start = 1; erase_sector = 0; sector_addr = AW'(23'h7FFFF);
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    // R10: start on the exact done pulse cycle
    do @(negedge clk); while (!(q.size() == 0 && last_busy));
    start = 1; erase_sector = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    // R7 R8: bit 6 steady with bit 7 low never completes
    do_start(1, AW'(23'h00F00), 0, 1);
    // R8: device toggles past the polling limit
    do_start(0, AW'(0), MAXP + 3, 0);
    // R6: completion exactly on the last allowed read
    do_start(1, AW'(23'h40001), MAXP - 1, 0);
    // R9: back-to-back request as soon as idle
    do_start(0, AW'(0), 1, 0);
    do @(negedge clk); while (q.size() != 0 || last_busy);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule